// File: doc/BRIEF.md
# SDRAM Command Decoder and Legality Monitor

This block watches the command pins of a four-bank single-data-rate SDRAM from the device side. On every rising clock edge it samples the clock-enable, chip-select, row/column strobe, write-enable, bank-select and address inputs. It turns them into one decoded command and reports the bank it targets, the row or column address and the auto-precharge request. It keeps track of which banks hold an open row, which bank is in an auto-precharge burst, and whether the device is running, in self refresh or in one of the two power-down states.

Every command is judged against that state and against the clock-enable history of the previous cycle. A command that is not allowed at that moment raises the violation output for one cycle. A flagged command does not change bank state. All outputs are registered and describe the command sampled at the most recent rising edge. The storage array and the data path are not part of this block.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With clock enable high at this edge and at the previous edge, the pins decode to `cmd_o` as follows. Chip select high gives 1 (deselect). With chip select low, the {ras,cas,we} values decode as: 111 gives 0 (no-op), 000 gives 2 (mode set), 001 gives 3 (auto refresh), 011 gives 5 (activate), 101 gives 6 (read), 100 gives 7 (write), 110 gives 8 (burst stop), and 010 gives 9 (precharge one bank).
- R2: `bank_o` is the bank index, with A=0, B=1, C=2 and D=3. `ba_i[1]` is bank bit 1 and `ba_i[0]` is bank bit 0. The bit pairs map as follows: {bit1,bit0}=00 gives 0, 10 gives 1, 01 gives 2 and 11 gives 3.
- R3: On activate, `row_o` carries the whole address bus. On read or write, `col_o` carries address bits 8..0 and `auto_pre_o` equals address bit 10. `auto_pre_o` is 0 for all other commands. A precharge with address bit 10 high decodes as 10 (precharge all), ignores the bank bits and closes every bank.
- R4: `bank_open_o[i]` is set by a legal activate to bank i and cleared by a legal precharge of bank i or by a legal precharge-all.
- R5: Mode set, auto refresh and self-refresh entry are flagged on `violation_o` when any bank is open.
- R6: For the 2 cycles after a legal mode set, any command other than no-op, deselect or a clock-enable transition is flagged.
- R7: Clock enable high at the previous edge and low now, with the refresh encoding, decodes as 4 (self-refresh entry) and sets `pwr_o` to 1. Clock enable low at the previous edge and high now decodes as 12 (exit) and returns `pwr_o` to 0 (running).
- R8: Clock enable falling with a no-op or deselect decodes as 11 (power-down entry). It sets `pwr_o` to 2 (precharge power-down) when no bank is open, and to 3 (active power-down) otherwise.
- R9: A read or write with auto precharge starts a burst of BURST_LEN cycles, counting the cycle of the access itself. Any read or write during that burst is flagged. The bank closes at the last edge of the burst, which is BURST_LEN-1 edges after the access.
- R10: A read, a write or a single-bank precharge to a bank with no open row is flagged.
- R11: While clock enable is low at both the previous and the current edge, the command pins are ignored. The block reports 13 (hold), and neither the power state nor the bank state changes.
- R12: A flagged command leaves `bank_open_o` unchanged.
- R13: Clock enable falling with any encoding other than no-op, deselect or refresh is flagged, and `pwr_o` stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge samples pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock enable pin |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank select pins |
| addr_i | input | ADDR_W | Address bus |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 2 | Target bank index |
| row_o | output | ADDR_W | Row address |
| col_o | output | COL_W | Column address |
| auto_pre_o | output | 1 | Auto precharge requested |
| pwr_o | output | 2 | Power state |
| violation_o | output | 1 | Illegal command seen |
| bank_open_o | output | 4 | Per-bank open-row flags |

## Verification
The burst counter of an auto-precharge access and the legality check of a new command can act at the same edge. At the last edge of the burst, the counter closes the bank, while a read that arrives at that edge must still be judged against the state before the edge. The bench issues a write with auto precharge and then places a read to another bank exactly BURST_LEN-1 cycles later. It expects that read to be flagged and the bursting bank to be reported closed after the same edge. One cycle later, a read to the other bank passes without a flag.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;
  typedef enum logic [3:0] {
    CMD_NOP      = 4'd0,
    CMD_DESEL    = 4'd1,
    CMD_MRS      = 4'd2,
    CMD_AREF     = 4'd3,
    CMD_SREF_IN  = 4'd4,
    CMD_ACT      = 4'd5,
    CMD_RD       = 4'd6,
    CMD_WR       = 4'd7,
    CMD_BST      = 4'd8,
    CMD_PRE      = 4'd9,
    CMD_PRE_ALL  = 4'd10,
    CMD_PD_IN    = 4'd11,
    CMD_PWR_EXIT = 4'd12,
    CMD_HOLD     = 4'd13
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_RUN      = 2'd0,
    PWR_SELF_REF = 2'd1,
    PWR_PRE_PD   = 2'd2,
    PWR_ACT_PD   = 2'd3
  } pwr_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cke_q_i,
  input  logic cke_i,
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  input  logic ap_bit_i,
  output cmd_e cmd_o,
  output logic cke_bad_o
);
  cmd_e pin_cmd;

  always_comb begin
    pin_cmd = CMD_NOP;
    if (cs_ni) begin
      pin_cmd = CMD_DESEL;
    end else begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b000: pin_cmd = CMD_MRS;
        3'b001: pin_cmd = CMD_AREF;
        3'b011: pin_cmd = CMD_ACT;
        3'b101: pin_cmd = CMD_RD;
        3'b100: pin_cmd = CMD_WR;
        3'b110: pin_cmd = CMD_BST;
        3'b010: pin_cmd = ap_bit_i ? CMD_PRE_ALL : CMD_PRE;
        default: pin_cmd = CMD_NOP;
      endcase
    end
  end

  always_comb begin
    cmd_o     = pin_cmd;
    cke_bad_o = 1'b0;
    if (!cke_q_i) begin
      cmd_o = cke_i ? CMD_PWR_EXIT : CMD_HOLD;
    end else if (!cke_i) begin
      if (pin_cmd == CMD_AREF) begin
        cmd_o = CMD_SREF_IN;
      end else if (pin_cmd == CMD_NOP || pin_cmd == CMD_DESEL) begin
        cmd_o = CMD_PD_IN;
      end else begin
        cke_bad_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
  parameter int unsigned BURST_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic pre_i,
  input  logic ap_start_i,
  output logic open_o,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(BURST_LEN + 1);
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(BURST_LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_o <= 1'b0;
      cnt_q  <= '0;
    end else if (pre_i) begin
      open_o <= 1'b0;
      cnt_q  <= '0;
    end else if (act_i) begin
      open_o <= 1'b1;
    end else if (ap_start_i) begin
      cnt_q <= LOAD_V;
      if (LOAD_V == '0) open_o <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) open_o <= 1'b0;
    end
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/sdram_pwr_track.sv
module sdram_pwr_track
  import sdram_mon_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cmd_e cmd_i,
  input  logic idle_i,
  output pwr_e pwr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_o <= PWR_RUN;
    end else begin
      unique case (cmd_i)
        CMD_SREF_IN:  pwr_o <= PWR_SELF_REF;
        CMD_PD_IN:    pwr_o <= idle_i ? PWR_PRE_PD : PWR_ACT_PD;
        CMD_PWR_EXIT: pwr_o <= PWR_RUN;
        default:      pwr_o <= pwr_o;
      endcase
    end
  end
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned COL_W     = 9,
  parameter int unsigned AP_BIT    = 10,
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned MRS_GAP   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              cs_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic [1:0]        ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [3:0]        cmd_o,
  output logic [1:0]        bank_o,
  output logic [ADDR_W-1:0] row_o,
  output logic [COL_W-1:0]  col_o,
  output logic              auto_pre_o,
  output logic [1:0]        pwr_o,
  output logic              violation_o,
  output logic [3:0]        bank_open_o
);
  localparam int unsigned BANKS = 4;
  localparam int unsigned GAP_W = $clog2(MRS_GAP + 1);

  cmd_e             cmd;
  logic             cke_bad;
  logic             cke_q;
  logic [1:0]       bank_sel;
  logic [BANKS-1:0] bank_open;
  logic [BANKS-1:0] bank_busy;
  logic [GAP_W-1:0] gap_q;
  logic             is_rdwr, any_open, any_busy;
  logic             v_idle, v_gap, v_ap, v_closed, viol;
  pwr_e             pwr;

  sdram_cmd_decode u_dec (
    .cke_q_i  (cke_q),
    .cke_i    (cke_i),
    .cs_ni    (cs_ni),
    .ras_ni   (ras_ni),
    .cas_ni   (cas_ni),
    .we_ni    (we_ni),
    .ap_bit_i (addr_i[AP_BIT]),
    .cmd_o    (cmd),
    .cke_bad_o(cke_bad)
  );

  assign bank_sel = {ba_i[0], ba_i[1]};
  assign is_rdwr  = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign any_open = |bank_open;
  assign any_busy = |bank_busy;

  assign v_idle   = any_open &&
                    (cmd == CMD_MRS || cmd == CMD_AREF || cmd == CMD_SREF_IN);
  assign v_gap    = (gap_q != '0) &&
                    !(cmd inside {CMD_NOP, CMD_DESEL, CMD_PD_IN, CMD_HOLD, CMD_PWR_EXIT});
  assign v_ap     = is_rdwr && any_busy;
  assign v_closed = (is_rdwr || cmd == CMD_PRE) && !bank_open[bank_sel];
  assign viol     = v_idle || v_gap || v_ap || v_closed || cke_bad;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (bank_sel == 2'(b));
    sdram_bank_track #(.BURST_LEN(BURST_LEN)) u_trk (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .act_i     (!viol && hit && cmd == CMD_ACT),
      .pre_i     (!viol && ((hit && cmd == CMD_PRE) || cmd == CMD_PRE_ALL)),
      .ap_start_i(!viol && hit && is_rdwr && addr_i[AP_BIT]),
      .open_o    (bank_open[b]),
      .busy_o    (bank_busy[b])
    );
  end

  sdram_pwr_track u_pwr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cmd_i (cmd),
    .idle_i(!any_open),
    .pwr_o (pwr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q <= 1'b1;
      gap_q <= '0;
    end else begin
      cke_q <= cke_i;
      if (cmd == CMD_MRS && !viol)  gap_q <= GAP_W'(MRS_GAP);
      else if (gap_q != '0)         gap_q <= gap_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o       <= CMD_NOP;
      bank_o      <= '0;
      row_o       <= '0;
      col_o       <= '0;
      auto_pre_o  <= 1'b0;
      violation_o <= 1'b0;
    end else begin
      cmd_o       <= cmd;
      bank_o      <= bank_sel;
      row_o       <= addr_i;
      col_o       <= addr_i[COL_W-1:0];
      auto_pre_o  <= is_rdwr && addr_i[AP_BIT];
      violation_o <= viol;
    end
  end

  assign pwr_o       = pwr;
  assign bank_open_o = bank_open;
endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk
  import sdram_mon_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] cmd_o,
  input logic [1:0] bank_o,
  input logic [1:0] pwr_o,
  input logic       violation_o,
  input logic [3:0] bank_open_o,
  input logic [3:0] bank_busy_i
);
  logic exempt;
  assign exempt = cmd_o inside {CMD_NOP, CMD_DESEL, CMD_PD_IN, CMD_HOLD, CMD_PWR_EXIT};

  assert_closed_access_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_RD || cmd_o == CMD_WR || cmd_o == CMD_PRE) &&
    (($past(bank_open_o) & (4'b0001 << bank_o)) == 4'b0000) |-> violation_o);

  assert_refresh_needs_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_AREF || cmd_o == CMD_MRS) && ($past(bank_open_o) != 4'b0000)
    |-> violation_o);

  assert_sref_state_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == CMD_SREF_IN |-> pwr_o == PWR_SELF_REF);

  assert_hold_no_pwr_change_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == CMD_HOLD |-> $stable(pwr_o));

  assert_flag_keeps_banks_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    violation_o && ($past(bank_busy_i) == 4'b0000) |-> $stable(bank_open_o));

  assert_mrs_gap_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cmd_o) == CMD_MRS) && !$past(violation_o) && !exempt |-> violation_o);

  assert_mrs_gap_second_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cmd_o, 2) == CMD_MRS) && !$past(violation_o, 2) && !exempt |-> violation_o);
endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_o      (cmd_o),
  .bank_o     (bank_o),
  .pwr_o      (pwr_o),
  .violation_o(violation_o),
  .bank_open_o(bank_open_o),
  .bank_busy_i(bank_busy)
);

// File: tb/sdram_cmd_monitor_bench.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_bench;
  localparam logic [2:0] P_MRS = 3'b000, P_REF = 3'b001, P_ACT = 3'b011,
                         P_RD  = 3'b101, P_WR  = 3'b100, P_BST = 3'b110,
                         P_PRE = 3'b010, P_NOP = 3'b111;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cke = 1'b1, cs_n = 1'b0;
  logic [2:0]  rcw = P_NOP;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [3:0]  cmd_o;
  logic [1:0]  bank_o, pwr_o;
  logic [11:0] row_o;
  logic [8:0]  col_o;
  logic        auto_pre_o, violation_o;
  logic [3:0]  bank_open_o;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  sdram_cmd_monitor u_sdram_cmd_monitor (
    .clk_i(clk), .rst_ni(rst_ni), .cke_i(cke), .cs_ni(cs_n),
    .ras_ni(rcw[2]), .cas_ni(rcw[1]), .we_ni(rcw[0]), .ba_i(ba), .addr_i(addr),
    .cmd_o(cmd_o), .bank_o(bank_o), .row_o(row_o), .col_o(col_o),
    .auto_pre_o(auto_pre_o), .pwr_o(pwr_o), .violation_o(violation_o),
    .bank_open_o(bank_open_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic k, input logic c, input logic [2:0] p,
                       input logic [1:0] b, input logic [11:0] a);
    @(negedge clk);
    cke = k; cs_n = c; rcw = p; ba = b; addr = a;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    chk("R1 reset cmd", cmd_o, 0);
    chk("R7 reset pwr", pwr_o, 0);
    chk("R4 reset banks", bank_open_o, 0);
    chk("R10 reset flag", violation_o, 0);
  endtask

  task automatic t_decode;
    issue(1, 0, P_ACT, 2'b01, 12'hABC);
    chk("R1 act code", cmd_o, 5); chk("R2 ba01 bank C", bank_o, 2);
    chk("R3 row", row_o, 'hABC); chk("R1 act flag", violation_o, 0);
    issue(1, 0, P_ACT, 2'b10, 12'h123);
    chk("R2 ba10 bank B", bank_o, 1); chk("R4 open", bank_open_o, 4'b0110);
    issue(1, 0, P_BST, 2'b00, 12'h0);
    chk("R1 burst stop", cmd_o, 8);
    issue(1, 1, P_ACT, 2'b00, 12'h0);
    chk("R1 deselect", cmd_o, 1); chk("R4 deselect no act", bank_open_o, 4'b0110);
    issue(1, 0, P_NOP, 2'b00, 12'h0);
    chk("R1 nop", cmd_o, 0);
    issue(1, 0, P_ACT, 2'b11, 12'h001);
    chk("R2 ba11 bank D", bank_o, 3);
    issue(1, 0, P_ACT, 2'b00, 12'h002);
    chk("R2 ba00 bank A", bank_o, 0); chk("R4 all open", bank_open_o, 4'b1111);
    issue(1, 0, P_PRE, 2'b00, 12'h0);
    chk("R1 pre code", cmd_o, 9);
    issue(1, 0, P_PRE, 2'b11, 12'h0);
    chk("R4 pre closes", bank_open_o, 4'b0110);
  endtask

  task automatic t_rdwr;
    issue(1, 0, P_RD, 2'b01, 12'h1F5);
    chk("R1 read code", cmd_o, 6); chk("R3 col", col_o, 'h1F5);
    chk("R3 no ap", auto_pre_o, 0); chk("R10 open read ok", violation_o, 0);
    issue(1, 0, P_WR, 2'b10, 12'h4AA);
    chk("R1 write code", cmd_o, 7); chk("R3 ap", auto_pre_o, 1);
    chk("R3 col ap", col_o, 'h0AA); chk("R9 write ok", violation_o, 0);
    issue(1, 0, P_RD, 2'b01, 12'h010);
    chk("R9 read in burst", violation_o, 1);
    issue(1, 0, P_NOP, 2'b00, 12'h0);
    chk("R9 still open", bank_open_o, 4'b0110);
    issue(1, 0, P_RD, 2'b01, 12'h010);
    chk("R9 last burst edge read", violation_o, 1);
    chk("R9 bank closed", bank_open_o, 4'b0100);
    issue(1, 0, P_RD, 2'b01, 12'h010);
    chk("R9 after burst", violation_o, 0);
    issue(1, 0, P_WR, 2'b10, 12'h010);
    chk("R10 write closed", violation_o, 1);
    issue(1, 0, P_PRE, 2'b00, 12'h0);
    chk("R10 pre closed", violation_o, 1);
    chk("R12 banks kept", bank_open_o, 4'b0100);
  endtask

  task automatic t_idle_mrs;
    issue(1, 0, P_REF, 2'b00, 12'h0);
    chk("R1 refresh code", cmd_o, 3); chk("R5 refresh open", violation_o, 1);
    issue(1, 0, P_MRS, 2'b00, 12'h0);
    chk("R1 mrs code", cmd_o, 2); chk("R5 mrs open", violation_o, 1);
    issue(1, 0, P_PRE, 2'b01, 12'h400);
    chk("R3 pre all code", cmd_o, 10); chk("R3 pre all closes", bank_open_o, 0);
    chk("R3 pre all flag", violation_o, 0);
    issue(1, 0, P_REF, 2'b00, 12'h0);
    chk("R5 refresh idle", violation_o, 0);
    issue(1, 0, P_MRS, 2'b00, 12'h033);
    chk("R5 mrs idle", violation_o, 0);
    issue(1, 0, P_ACT, 2'b00, 12'h0);
    chk("R6 gap 1", violation_o, 1); chk("R12 act flagged", bank_open_o, 0);
    issue(1, 0, P_NOP, 2'b00, 12'h0);
    chk("R6 nop allowed", violation_o, 0);
    issue(1, 0, P_ACT, 2'b00, 12'h0);
    chk("R6 gap over", violation_o, 0); chk("R4 act A", bank_open_o, 4'b0001);
  endtask

  task automatic t_power;
    issue(0, 0, P_NOP, 2'b00, 12'h0);
    chk("R8 pd code", cmd_o, 11); chk("R8 active pd", pwr_o, 3);
    issue(0, 0, P_ACT, 2'b01, 12'h0);
    chk("R11 hold code", cmd_o, 13); chk("R11 banks", bank_open_o, 4'b0001);
    chk("R11 pwr", pwr_o, 3); chk("R11 flag", violation_o, 0);
    issue(1, 0, P_NOP, 2'b00, 12'h0);
    chk("R7 exit code", cmd_o, 12); chk("R8 exit", pwr_o, 0);
    issue(0, 0, P_REF, 2'b00, 12'h0);
    chk("R5 sref open", violation_o, 1); chk("R7 sref code", cmd_o, 4);
    issue(1, 0, P_NOP, 2'b00, 12'h0);
    issue(1, 0, P_PRE, 2'b00, 12'h400);
    issue(0, 1, P_NOP, 2'b00, 12'h0);
    chk("R8 precharge pd", pwr_o, 2);
    issue(1, 0, P_NOP, 2'b00, 12'h0);
    issue(0, 0, P_REF, 2'b00, 12'h0);
    chk("R7 sref state", pwr_o, 1); chk("R7 sref legal", violation_o, 0);
    issue(0, 0, P_MRS, 2'b00, 12'h0);
    chk("R11 sref hold", pwr_o, 1);
    issue(1, 0, P_NOP, 2'b00, 12'h0);
    chk("R7 sref exit", pwr_o, 0);
    issue(0, 0, P_RD, 2'b00, 12'h0);
    chk("R13 bad cke fall", violation_o, 1); chk("R13 pwr run", pwr_o, 0);
    issue(1, 0, P_NOP, 2'b00, 12'h0);
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    t_reset;
    t_decode;
    t_rdwr;
    t_idle_mrs;
    t_power;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule